// File: doc/BRIEF.md
# Write-Only I2C Slave Receiver

This block is the bus-facing half of a single-channel converter's control port. It oversamples the two-wire serial clock and data lines with the system clock and finds start, repeated-start and stop conditions. It shifts in bytes most significant bit first and answers on the ninth clock with an open-drain acknowledge. It accepts three kinds of first byte. Its own write address is a fixed six-bit prefix, a select bit and a zero direction bit. A broadcast byte is accepted whatever the select input is. A high-speed master code is never acknowledged but raises a mode flag.

Once an address is accepted, every following byte is acknowledged. Each byte is handed to the downstream command decoder as a one-cycle strobe, together with its position in the transfer. A separate pulse marks the falling clock edge that ends each data acknowledge. The decoder uses that pulse as its update instant. A stop returns the block to idle and it then ignores the bus until a new start.

Top module: `i2cw_slave`

## Requirements
- R1: After reset `sda_pull_o`, `byte_vld_o`, `ack_done_o` and `hs_mode_o` are 0, and `byte_idx_o` is 0.
- R2: A first byte of 8'b1001_10s0, where s is the latched select level, is acknowledged: `sda_pull_o` is 1 while SCL is high in the ninth clock.
- R3: The broadcast byte 8'h90 is acknowledged whatever the select level is.
- R4: An address byte with the wrong select bit is not acknowledged, and the data bytes that follow it are neither acknowledged nor strobed.
- R5: The own address with the direction bit (bit 0) set to 1 is not acknowledged.
- R6: A first byte whose upper five bits are 5'b00001 is not acknowledged and sets `hs_mode_o`. A repeated start leaves `hs_mode_o` set, and a stop clears it.
- R7: After an accepted address, each received byte (MSB first) produces exactly one `byte_vld_o` cycle, with `byte_o` holding the byte. `byte_idx_o` is 0 for the first data byte and counts up by one per byte, saturating at its maximum.
- R8: Every data byte after an accepted address is acknowledged. `ack_done_o` pulses once at the falling SCL edge that ends that acknowledge, and `sda_pull_o` is released there.
- R9: A repeated start restarts the address phase and resets the byte index to 0.
- R10: After a stop, bytes clocked without a new start are ignored: they get no acknowledge and no strobe.
- R11: The select level is captured while reset is active. Later changes on `sel_i` do not change the accepted address.
- R12: The general call byte 8'h00 is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset; select level is captured while low |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sel_i | input | 1 | Address select input |
| sda_pull_o | output | 1 | 1 drives the data line low (open-drain enable) |
| byte_vld_o | output | 1 | One-cycle strobe for a received data byte |
| byte_o | output | 8 | Last received data byte |
| byte_idx_o | output | IDX_W | Position of the strobed byte after the address |
| ack_done_o | output | 1 | One-cycle pulse at the end of a data acknowledge |
| hs_mode_o | output | 1 | High-speed master code seen since the last stop |

## Verification
The assertions assume that the master keeps SCL low for several system clocks after each falling edge. They also assume that SDA changes only while SCL is low, except at start and stop, and that `sel_i` stays constant while reset is active. The bench drives the lines in quarter-bit steps of eight system clocks. It moves SDA only in the low phase of SCL, and it models the wired-AND of the master's drive and `sda_pull_o`. Under these conditions the acknowledge never overlaps a high SCL edge wrongly, and no false start or stop is produced.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ADDR,
      PH_ADDR_ACK,
      PH_DATA,
      PH_DATA_ACK,
      PH_SKIP
   } phase_t;

   typedef enum logic [1:0] {
      AC_REJECT,
      AC_ACCEPT,
      AC_HSCODE
   } addr_class_t;
endpackage

// File: rtl/i2cw_line_sync.sv
module i2cw_line_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          IDLE_LV = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("i2cw_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (!rst_n) chain <= {STAGES{IDLE_LV}};
      else        chain <= {chain[STAGES-2:0], d_i};
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/i2cw_cond_det.sv
module i2cw_cond_det (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_q, sda_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise  =  scl_s & ~scl_q;
   assign scl_fall  = ~scl_s &  scl_q;
   assign start_det =  scl_s &  scl_q &  sda_q & ~sda_s;
   assign stop_det  =  scl_s &  scl_q & ~sda_q &  sda_s;
endmodule

// File: rtl/i2cw_addr_dec.sv
module i2cw_addr_dec
   import i2cw_pkg::*;
#(
   parameter logic [5:0] DEV_PREFIX = 6'b100110,
   parameter bit         BCAST_EN   = 1'b1,
   parameter logic [7:0] BCAST_ADDR = 8'h90,
   parameter logic [4:0] HS_PREFIX  = 5'b00001
) (
   input  logic [7:0]  byte_i,
   input  logic        sel_i,
   output addr_class_t cls_o
);
   logic own_hit, bc_hit, hs_hit;

   assign own_hit = (byte_i == {DEV_PREFIX, sel_i, 1'b0});
   assign hs_hit  = (byte_i[7:3] == HS_PREFIX);

   if (BCAST_EN) begin : g_bcast
      assign bc_hit = (byte_i == BCAST_ADDR);
   end else begin : g_no_bcast
      assign bc_hit = 1'b0;
   end

   always_comb begin
      cls_o = AC_REJECT;
      if (hs_hit)                cls_o = AC_HSCODE;
      else if (own_hit || bc_hit) cls_o = AC_ACCEPT;
   end
endmodule

// File: rtl/i2cw_slave.sv
module i2cw_slave
   import i2cw_pkg::*;
#(
   parameter int unsigned NSYNC      = 2,
   parameter int unsigned IDX_W      = 4,
   parameter logic [5:0]  DEV_PREFIX = 6'b100110,
   parameter bit          BCAST_EN   = 1'b1,
   parameter logic [7:0]  BCAST_ADDR = 8'h90
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   input  logic             sel_i,
   output logic             sda_pull_o,
   output logic             byte_vld_o,
   output logic [7:0]       byte_o,
   output logic [IDX_W-1:0] byte_idx_o,
   output logic             ack_done_o,
   output logic             hs_mode_o
);
   localparam int unsigned BITS  = 8;
   localparam int unsigned CNT_W = $clog2(BITS + 1);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BITS);

   if (IDX_W < 1) begin : g_bad_idx
      $error("i2cw_slave: IDX_W must be at least 1");
   end

   logic scl_s, sda_s;
   logic scl_rise, scl_fall, start_det, stop_det;
   logic sel_lat;
   phase_t phase;
   logic [CNT_W-1:0] bit_cnt;
   logic [BITS-1:0]  shreg;
   addr_class_t      cls;

   i2cw_line_sync #(.STAGES(NSYNC), .IDLE_LV(1'b1)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_s));
   i2cw_line_sync #(.STAGES(NSYNC), .IDLE_LV(1'b1)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s));

   i2cw_cond_det u_cond (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det));

   i2cw_addr_dec #(
      .DEV_PREFIX(DEV_PREFIX), .BCAST_EN(BCAST_EN), .BCAST_ADDR(BCAST_ADDR)
   ) u_adec (
      .byte_i(shreg), .sel_i(sel_lat), .cls_o(cls));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase      <= PH_IDLE;
         bit_cnt    <= '0;
         shreg      <= '0;
         sel_lat    <= sel_i;
         sda_pull_o <= 1'b0;
         byte_vld_o <= 1'b0;
         byte_o     <= '0;
         byte_idx_o <= '0;
         ack_done_o <= 1'b0;
         hs_mode_o  <= 1'b0;
      end else begin
         byte_vld_o <= 1'b0;
         ack_done_o <= 1'b0;
         if (stop_det) begin
            phase      <= PH_IDLE;
            sda_pull_o <= 1'b0;
            hs_mode_o  <= 1'b0;
         end else if (start_det) begin
            phase      <= PH_ADDR;
            bit_cnt    <= '0;
            sda_pull_o <= 1'b0;
            byte_idx_o <= '0;
         end else begin
            unique case (phase)
               PH_ADDR, PH_DATA: begin
                  if (scl_rise && bit_cnt != LAST_BIT) begin
                     shreg   <= {shreg[BITS-2:0], sda_s};
                     bit_cnt <= bit_cnt + 1'b1;
                  end else if (scl_fall && bit_cnt == LAST_BIT) begin
                     if (phase == PH_ADDR) begin
                        unique case (cls)
                           AC_ACCEPT: begin
                              sda_pull_o <= 1'b1;
                              phase      <= PH_ADDR_ACK;
                           end
                           AC_HSCODE: begin
                              hs_mode_o <= 1'b1;
                              phase     <= PH_SKIP;
                           end
                           default: phase <= PH_SKIP;
                        endcase
                     end else begin
                        sda_pull_o <= 1'b1;
                        byte_vld_o <= 1'b1;
                        byte_o     <= shreg;
                        phase      <= PH_DATA_ACK;
                     end
                  end
               end
               PH_ADDR_ACK, PH_DATA_ACK: begin
                  if (scl_fall) begin
                     sda_pull_o <= 1'b0;
                     bit_cnt    <= '0;
                     phase      <= PH_DATA;
                     if (phase == PH_DATA_ACK) begin
                        ack_done_o <= 1'b1;
                        if (byte_idx_o != {IDX_W{1'b1}})
                           byte_idx_o <= byte_idx_o + 1'b1;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/i2cw_slave_chk.sv
module i2cw_slave_chk #(
   parameter int unsigned IDX_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             scl_s,
   input logic             stop_det,
   input logic             sel_lat,
   input logic             sda_pull_o,
   input logic             byte_vld_o,
   input logic [IDX_W-1:0] byte_idx_o,
   input logic             ack_done_o,
   input logic             hs_mode_o
);
   // R2: the acknowledge is only asserted while the synchronised SCL is low
   p_pull_on_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull_o) |-> !scl_s);

   // R7: a byte strobe lasts exactly one cycle
   p_vld_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld_o |=> !byte_vld_o);

   // R7: the index does not move in the cycle after a strobe
   p_idx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld_o |=> $stable(byte_idx_o));

   // R8: a strobed data byte is acknowledged
   p_vld_acks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld_o |-> sda_pull_o);

   // R8: the data line is released at the end of the acknowledge
   p_done_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ack_done_o |-> !sda_pull_o);

   // R6: a stop clears the high-speed flag
   p_hs_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !hs_mode_o);

   // R11: the latched select level never changes outside reset
   p_sel_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(sel_lat));
endmodule

bind i2cw_slave i2cw_slave_chk #(.IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_det(stop_det),
   .sel_lat(sel_lat), .sda_pull_o(sda_pull_o), .byte_vld_o(byte_vld_o),
   .byte_idx_o(byte_idx_o), .ack_done_o(ack_done_o), .hs_mode_o(hs_mode_o));

// File: tb/test_i2cw_slave.sv
module test_i2cw_slave;
   localparam int unsigned IDX_W = 4;
   localparam int unsigned TQ    = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sel = 1'b0;
   logic sda_pull, byte_vld, ack_done, hs_mode;
   logic [7:0] byte_val;
   logic [IDX_W-1:0] byte_idx;
   logic sda_line;

   int n_vec = 0;
   int n_bad = 0;
   int done_seen = 0;
   int done_exp = 0;
   bit finished = 0;
   logic [IDX_W+7:0] sb_q[$];
   logic [IDX_W-1:0] cur_idx;

   always #5 clk = ~clk;

   assign sda_line = sda_m & ~sda_pull;

   i2cw_slave #(.IDX_W(IDX_W)) i_i2cw_slave (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sel_i(sel),
      .sda_pull_o(sda_pull), .byte_vld_o(byte_vld), .byte_o(byte_val),
      .byte_idx_o(byte_idx), .ack_done_o(ack_done), .hs_mode_o(hs_mode));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && byte_vld) begin
         if (sb_q.size() == 0) begin
            chk(1'b0, "R4/R10 unexpected strobe", int'(byte_val), 0);
         end else begin
            logic [IDX_W+7:0] e;
            e = sb_q.pop_front();
            chk({byte_idx, byte_val} == e, "R7 strobe byte/index",
                int'({byte_idx, byte_val}), int'(e));
         end
      end
      if (rst_n && ack_done) done_seen++;
   end

   task automatic wq();
      repeat (TQ) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wq();
      scl_m = 1'b1; wq();
      sda_m = 1'b0; wq();
      scl_m = 1'b0; wq();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wq();
      scl_m = 1'b1; wq();
      sda_m = 1'b1; wq();
   endtask

   task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
      bit got;
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; wq();
         scl_m = 1'b1; wq(); wq();
         scl_m = 1'b0; wq();
      end
      sda_m = 1'b1; wq();
      scl_m = 1'b1; wq();
      got = ~sda_line;
      wq();
      scl_m = 1'b0; wq();
      chk(got == exp_ack, req, int'(got), int'(exp_ack));
   endtask

   task automatic send_data(input logic [7:0] b, input string req);
      sb_q.push_back({cur_idx, b});
      done_exp++;
      send_byte(b, 1'b1, req);
      cur_idx++;
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      report();
   end

   initial begin
      repeat (6) @(negedge clk);
      // R1 reset state
      chk({sda_pull, byte_vld, ack_done, hs_mode} == 4'b0, "R1 reset flags",
          int'({sda_pull, byte_vld, ack_done, hs_mode}), 0);
      chk(byte_idx == '0, "R1 reset index", int'(byte_idx), 0);
      rst_n = 1'b1;
      wq();

      // R2 own address, R7/R8 three data bytes
      bus_start(); cur_idx = '0;
      send_byte(8'h98, 1'b1, "R2 own address ack");
      send_data(8'hA5, "R8 data ack 0");
      send_data(8'h3C, "R8 data ack 1");
      send_data(8'hFF, "R8 data ack 2");
      bus_stop();
      chk(done_seen == done_exp, "R8 ack_done count", done_seen, done_exp);

      // R3 broadcast
      bus_start(); cur_idx = '0;
      send_byte(8'h90, 1'b1, "R3 broadcast ack");
      send_data(8'h5A, "R3 data after broadcast");
      bus_stop();

      // R4 wrong select bit, following data ignored
      bus_start();
      send_byte(8'h9A, 1'b0, "R4 wrong select nack");
      send_byte(8'h11, 1'b0, "R4 data ignored");
      bus_stop();

      // R5 read direction
      bus_start();
      send_byte(8'h99, 1'b0, "R5 read nack");
      bus_stop();

      // R12 general call
      bus_start();
      send_byte(8'h00, 1'b0, "R12 general call nack");
      bus_stop();

      // R6 HS master code, R9 repeated start
      bus_start();
      send_byte(8'h0B, 1'b0, "R6 hs code nack");
      chk(hs_mode == 1'b1, "R6 hs flag set", int'(hs_mode), 1);
      bus_start(); cur_idx = '0;
      send_byte(8'h98, 1'b1, "R6 address after hs code");
      chk(hs_mode == 1'b1, "R6 hs kept over repeated start", int'(hs_mode), 1);
      send_data(8'h77, "R9 data idx0");
      bus_start(); cur_idx = '0;
      send_byte(8'h90, 1'b1, "R9 repeated start address");
      send_data(8'h12, "R9 index reset");
      bus_stop();
      wq();
      chk(hs_mode == 1'b0, "R6 hs cleared by stop", int'(hs_mode), 0);

      // R10 traffic after stop without start
      bus_start(); cur_idx = '0;
      send_byte(8'h98, 1'b1, "R10 address");
      send_data(8'h44, "R10 data before stop");
      bus_stop();
      scl_m = 1'b0; wq();
      send_byte(8'h55, 1'b0, "R10 byte after stop ignored");
      scl_m = 1'b1; wq();
      bus_stop();

      // R11 select change after reset has no effect
      sel = 1'b1; wq();
      bus_start(); cur_idx = '0;
      send_byte(8'h98, 1'b1, "R11 latched select still 0");
      send_data(8'h66, "R11 data");
      bus_stop();
      bus_start();
      send_byte(8'h9A, 1'b0, "R11 new select level ignored");
      bus_stop();

      wq();
      chk(sb_q.size() == 0, "R7 all expected strobes seen", sb_q.size(), 0);
      chk(done_seen == done_exp, "R8 total ack_done pulses", done_seen, done_exp);
      report();
   end
endmodule